// File: doc/BRIEF.md
# Single-Accumulator File-Register Execution Core

This block executes 14-bit instruction words for a small controller built around one working accumulator (W) and a 128-byte register file. Each word is decoded in a single clock and run at once. Byte operations read one file register, combine it with W and write the result back to W or to that file register. Literal operations work on W and an 8-bit constant. Bit operations set, clear or test a single file bit. Jumps and one-level calls carry an 11-bit target.

File register 0x06 drives an 8-bit output port. Programs are written into a small internal program memory through a write port, and only while reset is held. Execution begins at address 0 on the first clock after reset is released. A sleep word freezes the core until the next reset.

Top module: `w_file_core`

## Requirements
- R1: While rst_n is low the core holds pc_out=0, w_out=0, zero=0, halted=0 and port_b=0, and clears every file register. Words presented with pm_we=1 during reset are stored at pm_waddr.
- R2: Byte operations take the file address from bits 6:0 and the destination from bit 7 (0 writes W, 1 writes the file register). Bits 13:8 select the operation: 000111 add, 000101 AND, 000100 OR, 000110 XOR, 000010 subtract, 001000 move, 001001 complement, 001010 increment, 000011 decrement, 001110 nibble swap, 000001 clear.
- R3: When bits 13:7 are 0000000 1, W is written to the addressed file register. Literal operations take the constant from bits 7:0: 1100xx loads W, 111000 ORs it into W, 111001 ANDs, 111010 XORs, 11110x gives literal minus W, and 11111x adds.
- R4: Subtraction is modulo 256 and computes the file value (or the literal) minus W. The zero flag is set to (result==0) by add, subtract, AND, OR, XOR, move-from-file, complement, increment, decrement and clear. It is left unchanged by all other words.
- R5: Bit operations take the bit index from bits 9:7 and the file address from bits 6:0. Top bits 0100 clear the bit and 0101 set it.
- R6: Top bits 0110 skip the next word when the bit is clear, and 0111 skip it when the bit is set. Opcode 001011 (decrement) and 001111 (increment) write their result and skip when that result is zero. A skip advances pc by 2.
- R7: A word with top bits 101 jumps to bits 10:0. A word with top bits 100 also jumps there and saves pc+1 in a one-entry stack, so a nested call overwrites the saved address. Word 0x0008 returns to the saved address. Top bits 1101xx return there and load W with bits 7:0.
- R8: port_b always shows the contents of file register 0x06.
- R9: Word 0x0063 stops execution with pc held on the sleep word. halted goes high and no state changes until reset.
- R10: Every other word completes in one clock. Without a jump, skip or sleep, pc advances by 1 per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; program loading is allowed while low |
| pm_we | input | 1 | Program memory write enable (effective only in reset) |
| pm_waddr | input | $clog2(PM_DEPTH) | Program memory write address |
| pm_wdata | input | 14 | Instruction word to store |
| port_b | output | 8 | Output port, mirror of file register 0x06 |
| w_out | output | 8 | Current W value |
| zero | output | 1 | Zero flag |
| pc_out | output | 11 | Program counter |
| halted | output | 1 | High after a sleep word has executed |

## Verification
Three behaviours are hard to reach from the ports: the skip taken by a decrement or increment loop on its last pass, a return that follows a call nested inside a loop, and a bit test on the port register right after it was written. Each of these needs a program built so that the state reaches exactly that point. The bench loads such programs during reset, then compares pc, W, the zero flag, the port and the halt state against a behavioural model on every clock. Each program ends in a sleep word, and directed checks then confirm the final port and W values worked out by hand.

// File: rtl/w_file_core.sv
module w_file_core #(
  parameter int PM_DEPTH  = 64,
  parameter int PORT_ADDR = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pm_we,
  input  logic [$clog2(PM_DEPTH)-1:0] pm_waddr,
  input  logic [13:0]                 pm_wdata,
  output logic [7:0]                  port_b,
  output logic [7:0]                  w_out,
  output logic                        zero,
  output logic [10:0]                 pc_out,
  output logic                        halted
);
  localparam int PAW       = $clog2(PM_DEPTH);
  localparam int FILE_SIZE = 128;

  logic [13:0] pmem [PM_DEPTH];
  logic [7:0]  fmem [FILE_SIZE];
  logic [10:0] pc, stk;
  logic [7:0]  w;
  logic        z;

  wire [13:0] ir    = pmem[pc[PAW-1:0]];
  wire [6:0]  fa    = ir[6:0];
  wire        d     = ir[7];
  wire [7:0]  k     = ir[7:0];
  wire [7:0]  fv    = fmem[fa];
  wire [7:0]  bmask = 8'd1 << ir[9:7];
  wire [10:0] pc1   = pc + 11'd1;
  wire [10:0] pc2   = pc + 11'd2;

  logic [7:0]  res;
  logic        wr_w, wr_f, upd_z, push, sleep_now;
  logic [10:0] npc;

  always_comb begin
    res = fv; wr_w = 1'b0; wr_f = 1'b0; upd_z = 1'b0;
    push = 1'b0; sleep_now = 1'b0; npc = pc1;
    case (ir[13:12])
      2'b00: begin
        wr_w = ~d; wr_f = d; upd_z = 1'b1;
        case (ir[11:8])
          4'h0: begin
            wr_w = 1'b0; wr_f = d; upd_z = 1'b0; res = w;
            if (!d && ir[6:0] == 7'h08) npc = stk;
            else if (!d && ir[6:0] == 7'h63) sleep_now = 1'b1;
          end
          4'h1: res = 8'h00;
          4'h2: res = fv - w;
          4'h3: res = fv - 8'd1;
          4'h4: res = fv | w;
          4'h5: res = fv & w;
          4'h6: res = fv ^ w;
          4'h7: res = fv + w;
          4'h8: res = fv;
          4'h9: res = ~fv;
          4'hA: res = fv + 8'd1;
          4'hB: begin res = fv - 8'd1; upd_z = 1'b0; if (res == 8'h00) npc = pc2; end
          4'hE: begin res = {fv[3:0], fv[7:4]}; upd_z = 1'b0; end
          4'hF: begin res = fv + 8'd1; upd_z = 1'b0; if (res == 8'h00) npc = pc2; end
          default: begin wr_w = 1'b0; wr_f = 1'b0; upd_z = 1'b0; end
        endcase
      end
      2'b01: begin
        case (ir[11:10])
          2'b00: begin res = fv & ~bmask; wr_f = 1'b1; end
          2'b01: begin res = fv | bmask;  wr_f = 1'b1; end
          2'b10: if ((fv & bmask) == 8'h00) npc = pc2;
          default: if ((fv & bmask) != 8'h00) npc = pc2;
        endcase
      end
      2'b10: begin
        npc = ir[10:0];
        push = ~ir[11];
      end
      default: begin
        wr_w = 1'b1; upd_z = 1'b1;
        casez (ir[11:8])
          4'b00??: begin res = k; upd_z = 1'b0; end
          4'b01??: begin res = k; upd_z = 1'b0; npc = stk; end
          4'b1000: res = k | w;
          4'b1001: res = k & w;
          4'b1010: res = k ^ w;
          4'b110?: res = k - w;
          4'b111?: res = k + w;
          default: begin wr_w = 1'b0; upd_z = 1'b0; end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk)
    if (!rst_n && pm_we) pmem[pm_waddr] <= pm_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; stk <= '0; w <= '0; z <= 1'b0; halted <= 1'b0;
      for (int i = 0; i < FILE_SIZE; i++) fmem[i] <= '0;
    end else if (!halted) begin
      if (sleep_now) halted <= 1'b1;
      else begin
        pc <= npc;
        if (push)  stk <= pc1;
        if (wr_w)  w <= res;
        if (wr_f)  fmem[fa] <= res;
        if (upd_z) z <= (res == 8'h00);
      end
    end
  end

  assign port_b = fmem[PORT_ADDR];
  assign w_out  = w;
  assign zero   = z;
  assign pc_out = pc;
endmodule

module w_file_core_chk #(parameter int PORT_ADDR = 6) (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] ir,
  input logic [10:0] pc,
  input logic [7:0]  w_q,
  input logic        z_q,
  input logic        halted,
  input logic        wr_f,
  input logic [6:0]  fa,
  input logic [7:0]  port_b
);
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(w_q) && $stable(port_b));

  a_r8_port_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_f || fa != 7'(PORT_ADDR)) |=> $stable(port_b));

  a_r7_goto_target: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && ir[13:11] == 3'b101) |=> pc == $past(ir[10:0]));

  a_r6_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && ir[13:12] == 2'b01 && ir[11]) |=>
      (pc == $past(pc) + 11'd1) || (pc == $past(pc) + 11'd2));

  a_r4_andlw_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && ir[13:8] == 6'b111001) |=>
      (w_q == ($past(w_q) & $past(ir[7:0]))) && (z_q == (w_q == 8'h00)));

  a_r10_plain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && ir[13:12] == 2'b11 && ir[11:8] == 4'b1000) |=> pc == $past(pc) + 11'd1);
endmodule

bind w_file_core w_file_core_chk #(.PORT_ADDR(PORT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ir(ir), .pc(pc), .w_q(w), .z_q(z),
  .halted(halted), .wr_f(wr_f), .fa(fa), .port_b(port_b));

// File: tb/w_file_core_tb.sv
`timescale 1ns/1ps
module w_file_core_tb;
  logic clk = 1'b0, rst_n = 1'b0, pm_we = 1'b0;
  logic [5:0] pm_waddr = '0;
  logic [13:0] pm_wdata = '0;
  logic [7:0] port_b, w_out;
  logic zero, halted;
  logic [10:0] pc_out;

  w_file_core u_dut (.clk(clk), .rst_n(rst_n), .pm_we(pm_we), .pm_waddr(pm_waddr),
    .pm_wdata(pm_wdata), .port_b(port_b), .w_out(w_out), .zero(zero),
    .pc_out(pc_out), .halted(halted));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int m_prog[64];
  int m_f[128];
  int m_pc, m_w, m_z, m_halt, m_stk;
  int plen;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_w = 0; m_z = 0; m_halt = 0; m_stk = 0;
    foreach (m_f[i]) m_f[i] = 0;
  endtask

  task automatic model_step();
    int ins, f, v, r, dst, nxt, lit, bit_on;
    if (m_halt) return;
    ins = m_prog[m_pc % 64];
    f = ins & 127; dst = (ins >> 7) & 1; lit = ins & 255;
    v = m_f[f]; nxt = (m_pc + 1) & 2047;
    bit_on = (v >> ((ins >> 7) & 7)) & 1;
    if (ins == 'h0063) begin m_halt = 1; return; end
    if (ins == 'h0008) nxt = m_stk;
    else if ((ins >> 7) == 1) m_f[f] = m_w;
    else if ((ins >> 12) == 0 && ((ins >> 8) & 15) != 0) begin
      int op = (ins >> 8) & 15;
      int zf = 1;
      r = v;
      if (op == 1) r = 0;
      else if (op == 2) r = (v - m_w) & 255;
      else if (op == 3 || op == 11) r = (v + 255) & 255;
      else if (op == 4) r = v | m_w;
      else if (op == 5) r = v & m_w;
      else if (op == 6) r = v ^ m_w;
      else if (op == 7) r = (v + m_w) & 255;
      else if (op == 9) r = (~v) & 255;
      else if (op == 10 || op == 15) r = (v + 1) & 255;
      else if (op == 14) r = ((v << 4) | (v >> 4)) & 255;
      if (op == 11 || op == 14 || op == 15) zf = 0;
      if ((op == 11 || op == 15) && r == 0) nxt = (m_pc + 2) & 2047;
      if (op != 12 && op != 13) begin
        if (dst) m_f[f] = r; else m_w = r;
        if (zf) m_z = (r == 0);
      end
    end
    else if ((ins >> 12) == 1) begin
      int sub = (ins >> 10) & 3;
      int b = (ins >> 7) & 7;
      if (sub == 0) m_f[f] = v & ~(1 << b) & 255;
      else if (sub == 1) m_f[f] = v | (1 << b);
      else if (sub == 2 && !bit_on) nxt = (m_pc + 2) & 2047;
      else if (sub == 3 && bit_on) nxt = (m_pc + 2) & 2047;
    end
    else if ((ins >> 12) == 2) begin
      if (((ins >> 11) & 1) == 0) m_stk = (m_pc + 1) & 2047;
      nxt = ins & 2047;
    end
    else if ((ins >> 12) == 3) begin
      int sel = (ins >> 8) & 15;
      if (sel < 4) m_w = lit;
      else if (sel < 8) begin m_w = lit; nxt = m_stk; end
      else if (sel == 8) begin m_w = lit | m_w; m_z = (m_w == 0); end
      else if (sel == 9) begin m_w = lit & m_w; m_z = (m_w == 0); end
      else if (sel == 10) begin m_w = lit ^ m_w; m_z = (m_w == 0); end
      else if (sel == 12 || sel == 13) begin m_w = (lit - m_w) & 255; m_z = (m_w == 0); end
      else if (sel >= 14) begin m_w = (lit + m_w) & 255; m_z = (m_w == 0); end
    end
    m_pc = nxt;
  endtask

  task automatic compare_all();
    chk("R7", "pc", int'(pc_out), m_pc);
    chk("R2", "w", int'(w_out), m_w);
    chk("R4", "zero", int'(zero), m_z);
    chk("R8", "port_b", int'(port_b), m_f[6]);
    chk("R9", "halted", int'(halted), m_halt);
  endtask

  task automatic run_prog(int cycles);
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      pm_we = 1'b1; pm_waddr = 6'(i); pm_wdata = 14'(m_prog[i]);
    end
    @(negedge clk); pm_we = 1'b0;
    model_reset();
    chk("R1", "reset pc", int'(pc_out), 0);
    chk("R1", "reset w", int'(w_out), 0);
    chk("R1", "reset port", int'(port_b), 0);
    chk("R1", "reset halted", int'(halted), 0);
    rst_n = 1'b1;
    for (int c = 0; c < cycles; c++) begin
      model_step();
      @(negedge clk);
      compare_all();
    end
  endtask

  function automatic int fop(int op, int d, int f);
    return (op << 8) | (d << 7) | f;
  endfunction

  bit done = 1'b0;
  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // program A: byte and literal operations, destination bit, zero flag
    foreach (m_prog[i]) m_prog[i] = 0;
    m_prog[0] = 'h3005; m_prog[1] = 'h008C; m_prog[2] = 'h3002;
    m_prog[3] = fop('h07, 1, 'h0C); m_prog[4] = fop('h08, 0, 'h0C);
    m_prog[5] = 'h3C07; m_prog[6] = 'h3AFF; m_prog[7] = 'h0086;
    m_prog[8] = fop('h02, 0, 'h0C); m_prog[9] = fop('h05, 1, 'h06);
    m_prog[10] = fop('h09, 1, 'h0C); m_prog[11] = fop('h0E, 0, 'h0C);
    m_prog[12] = 'h3801; m_prog[13] = 'h3900; m_prog[14] = fop('h01, 1, 'h06);
    m_prog[15] = fop('h0A, 1, 'h06); m_prog[16] = fop('h03, 1, 'h0C);
    m_prog[17] = 'h0100; m_prog[18] = 'h3EFF; m_prog[19] = fop('h06, 1, 'h0C);
    m_prog[20] = fop('h04, 1, 'h06); m_prog[21] = 'h0063;
    run_prog(30);
    chk("R3", "A final w", int'(w_out), 'hFF);
    chk("R8", "A final port", int'(port_b), 'hFF);
    chk("R9", "A sleep pc", int'(pc_out), 21);

    // program B: bit operations, skips, call, decrement loop, return with literal
    foreach (m_prog[i]) m_prog[i] = 0;
    m_prog[0] = 'h3003; m_prog[1] = 'h008D; m_prog[2] = 'h200C;
    m_prog[3] = 'h1786; m_prog[4] = 'h1F86; m_prog[5] = 'h1406;
    m_prog[6] = 'h1806; m_prog[7] = 'h1486; m_prog[8] = 'h280A;
    m_prog[9] = 'h1506; m_prog[10] = 'h1386; m_prog[11] = 'h0063;
    m_prog[12] = fop('h0B, 1, 'h0D); m_prog[13] = 'h280C; m_prog[14] = 'h345A;
    run_prog(30);
    chk("R7", "B retlw w", int'(w_out), 'h5A);
    chk("R5", "B port after set/clear", int'(port_b), 'h00);
    chk("R6", "B sleep pc", int'(pc_out), 11);

    // program C: increment loop skip, plain return, port write
    foreach (m_prog[i]) m_prog[i] = 0;
    m_prog[0] = 'h30FE; m_prog[1] = 'h008E; m_prog[2] = 'h2006;
    m_prog[3] = 'h0086; m_prog[4] = 'h0063; m_prog[5] = 'h0000;
    m_prog[6] = fop('h0F, 1, 'h0E); m_prog[7] = 'h2806;
    m_prog[8] = 'h3055; m_prog[9] = 'h0008;
    run_prog(20);
    chk("R8", "C port", int'(port_b), 'h55);
    chk("R10", "C halted", int'(halted), 1);
    chk("R6", "C sleep pc", int'(pc_out), 4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule